// File: doc/BRIEF.md
# Two-Channel Action-Qualified PWM Generator

This block drives two pulse-width-modulated outputs, `pwm_a` and `pwm_b`, from one shared time-base counter. A prescaler turns the system clock into a tick enable. On each tick the counter steps in one of four modes: up, down, up-down or frozen. Each tick can raise events: counter at zero, counter at period, and a match on either of two compare values while the counter counts up or while it counts down.

Each output has its own action table. The table says whether each event drives the output low, drives it high, toggles it or leaves it alone. The same table can therefore give normal or inverted polarity, edge-aligned or centre-aligned pulses, or a plain square wave. The period and both compare values can be shadowed, so a new value written in mid-cycle takes effect only at a chosen counter event. A continuous software force per output can pin that output low or high whatever the events do.

All configuration comes through a single-cycle register write port. Every register clears on reset.

Top module: `pwm_dual_aq`

## Requirements
- R1: A write is accepted on any clock edge where `cfg_we` is high, using `cfg_addr` and `cfg_wdata`. The register addresses are:
  - 0: timing control. Bits [1:0] are the counter mode, bit 2 is the period load select, bits [5:3] are the coarse divider exponent and bits [8:6] are the fine divider.
  - 1: period.
  - 2: compare control. Bit 0 is the shadow enable for compare A and bits [2:1] are its load point. Bit 3 is the shadow enable for compare B and bits [5:4] are its load point.
  - 3: compare A.
  - 4: compare B.
  - 5: output A action table.
  - 6: output B action table.
  - 7: software force.
- R2: Synchronous active-high reset clears every register, the counter and both outputs. With all registers at zero, both outputs stay low after reset.
- R3: A tick occurs once every 2^E × F clock cycles, where E is the coarse exponent and F is twice the fine divider value, or 1 when the fine divider is 0. The counter steps and events are raised only on ticks, so an output changes only on the clock edge after a tick or after a force change.
- R4: Counter mode 0 (up) counts 0, 1, …, P and then wraps to 0, so one period is (P+1) ticks, where P is the period value. With the zero action set to drive high and the compare-A-up action set to drive low, output A is high for C ticks in each period, where C is the compare A value.
- R5: Counter mode 1 (down) counts P, P−1, …, 0 and then reloads P. With the zero action set to drive high and the compare-A-down action set to drive low, output A is high for (P−C+1) ticks in each period of (P+1) ticks.
- R6: Counter mode 2 (up-down) counts 0 up to P and back down to 0, so one period is 2P ticks. With the compare-A-up action set to drive high and the compare-A-down action set to drive low, output A is high for 2(P−C) ticks.
- R7: Counter mode 3 holds the counter and raises no events, so both outputs keep their values while the mode stays 3.
- R8: Period load select 1 makes a written period take effect at once. Load select 0 makes it take effect at the next tick where the counter is at zero.
- R9: With its shadow enable at 0, a compare value takes effect at once. With the shadow enable at 1, the written value moves to the active compare only at the chosen load point: 0 at counter zero, 1 at period, 2 at either, and 3 never.
- R10: An action table is a 12-bit word made of six 2-bit fields, one per event. Bits [1:0] are for zero, [3:2] for period, [5:4] for compare A up, [7:6] for compare A down, [9:8] for compare B up and [11:10] for compare B down. Code 0 does nothing, 1 drives low, 2 drives high and 3 toggles.
- R11: When several events with non-zero actions fall on the same tick, the priority from lowest to highest is zero, period, compare A, compare B. As a result, a compare value of 0 with zero→high and compare-A-up→low gives a constant low output.
- R12: The software force register has two bits per channel: bits [1:0] for A and bits [3:2] for B. Code 1 pins the output low and code 2 pins it high, from the next clock edge on. While pinned, the output ignores its action table. Codes 0 and 3 release the output, and the other channel is not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 16 | Register write data |
| pwm_a | output | 1 | PWM output A, registered |
| pwm_b | output | 1 | PWM output B, registered |

## Verification
The hardest case to reach from the ports is the shadowed compare. Its active value cannot be read back, so its effect can be seen only in the duty of later pulses. The stimulus first sets compare A with the shadow off, then enables the shadow with the never-load point and writes a new value. It then confirms that the pulse width stays the same, switches the load point to zero and then to period, and measures the new width after each switch. Same-tick priority is reached by setting the compare to 0, so that the compare match and the zero event always coincide.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_TIME   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPCTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPA   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMPB   = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACTA   = 3'd5;
  localparam logic [ADDR_W-1:0] A_ACTB   = 3'd6;
  localparam logic [ADDR_W-1:0] A_FORCE  = 3'd7;

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_UPDOWN = 2'd2,
    CM_FREEZE = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    LD_ZERO   = 2'd0,
    LD_PRD    = 2'd1,
    LD_EITHER = 2'd2,
    LD_NEVER  = 2'd3
  } load_sel_e;

  // Field order sets the bit layout: at_zero sits in bits [1:0].
  typedef struct packed {
    act_e cmpb_dn;
    act_e cmpb_up;
    act_e cmpa_dn;
    act_e cmpa_up;
    act_e at_prd;
    act_e at_zero;
  } action_cfg_t;

  typedef struct packed {
    logic cmpb_dn;
    logic cmpb_up;
    logic cmpa_dn;
    logic cmpa_up;
    logic at_prd;
    logic at_zero;
  } event_t;

endpackage

// File: rtl/pwm_aq_prescale.sv
module pwm_aq_prescale #(
  parameter int DIV_W = 3,
  parameter int HS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] clkdiv,
  input  logic [HS_W-1:0]  hsdiv,
  output logic             tick
);
  // Wide enough for (2^(2^DIV_W-1)) * (2*(2^HS_W-1)).
  localparam int PS_W = (1 << DIV_W) + HS_W + 1;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] coarse_f;
  logic [PS_W-1:0] fine_f;
  logic [PS_W-1:0] div_m1;

  always_comb begin
    coarse_f = PS_W'(1) << clkdiv;
    fine_f   = (hsdiv == '0) ? PS_W'(1) : PS_W'({hsdiv, 1'b0});
    div_m1   = coarse_f * fine_f - PS_W'(1);
  end

  // Greater-or-equal so that a smaller divider written mid-count ends the count at once.
  assign tick = (ps_q >= div_m1);

  always_ff @(posedge clk) begin
    if (rst) ps_q <= '0;
    else if (tick) ps_q <= '0;
    else ps_q <= ps_q + PS_W'(1);
  end
endmodule

// File: rtl/pwm_aq_timebase.sv
module pwm_aq_timebase
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  cnt_mode_e        mode,
  input  logic             per_imm,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_eff,
  output logic             dir_up,
  output logic             ev_zero,
  output logic             ev_prd
);
  logic [CNT_W-1:0] cnt_q, cnt_d, per_sh_q, per_act_q;
  logic             dir_q, dir_d;

  assign run     = tick && (mode != CM_FREEZE);
  assign per_eff = per_imm ? per_sh_q : per_act_q;
  assign cnt     = cnt_q;
  assign ev_zero = run && (cnt_q == '0);
  assign ev_prd  = run && (cnt_q == per_eff);

  always_comb begin
    unique case (mode)
      CM_UP:   dir_up = 1'b1;
      CM_DOWN: dir_up = 1'b0;
      default: dir_up = dir_q;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    unique case (mode)
      CM_UP: begin
        dir_d = 1'b1;
        cnt_d = (cnt_q >= per_eff) ? '0 : cnt_q + CNT_W'(1);
      end
      CM_DOWN: begin
        dir_d = 1'b0;
        cnt_d = (cnt_q == '0) ? per_eff : cnt_q - CNT_W'(1);
      end
      CM_UPDOWN: begin
        if (dir_q) begin
          if (cnt_q >= per_eff) begin
            dir_d = 1'b0;
            cnt_d = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end else begin
          if (cnt_q == '0) begin
            dir_d = 1'b1;
            cnt_d = (per_eff == '0) ? '0 : CNT_W'(1);
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      default: begin
        cnt_d = cnt_q;
        dir_d = dir_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      dir_q     <= 1'b0;
      per_sh_q  <= '0;
      per_act_q <= '0;
    end else begin
      if (per_we) per_sh_q <= per_wdata;
      if (per_imm || ev_zero) per_act_q <= per_sh_q;
      if (run) begin
        cnt_q <= cnt_d;
        dir_q <= dir_d;
      end
    end
  end
endmodule

// File: rtl/pwm_aq_compare.sv
module pwm_aq_compare
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             shadow_en,
  input  load_sel_e        load_sel,
  input  logic             run,
  input  logic             ev_zero,
  input  logic             ev_prd,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_up,
  output logic [CNT_W-1:0] cmp_eff,
  output logic             ev_up,
  output logic             ev_dn
);
  logic [CNT_W-1:0] sh_q, act_q;
  logic             take;

  always_comb begin
    unique case (load_sel)
      LD_ZERO:   take = ev_zero;
      LD_PRD:    take = ev_prd;
      LD_EITHER: take = ev_zero || ev_prd;
      default:   take = 1'b0;
    endcase
  end

  assign cmp_eff = shadow_en ? act_q : sh_q;
  assign ev_up   = run && dir_up  && (cnt == cmp_eff);
  assign ev_dn   = run && !dir_up && (cnt == cmp_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      if (we) sh_q <= wdata;
      // With the shadow off the active copy tracks the written value, so turning the shadow on holds the current value.
      if (!shadow_en || take) act_q <= sh_q;
    end
  end
endmodule

// File: rtl/pwm_aq_output.sv
module pwm_aq_output
  import pwm_aq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  action_cfg_t cfg,
  input  event_t      ev,
  input  logic [1:0]  force_sel,
  output logic        pwm
);
  act_e sel;
  logic pwm_q;

  // Later assignments win: zero < period < compare A < compare B.
  always_comb begin
    sel = ACT_NONE;
    if (ev.at_zero && cfg.at_zero != ACT_NONE) sel = cfg.at_zero;
    if (ev.at_prd  && cfg.at_prd  != ACT_NONE) sel = cfg.at_prd;
    if (ev.cmpa_up && cfg.cmpa_up != ACT_NONE) sel = cfg.cmpa_up;
    if (ev.cmpa_dn && cfg.cmpa_dn != ACT_NONE) sel = cfg.cmpa_dn;
    if (ev.cmpb_up && cfg.cmpb_up != ACT_NONE) sel = cfg.cmpb_up;
    if (ev.cmpb_dn && cfg.cmpb_dn != ACT_NONE) sel = cfg.cmpb_dn;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else if (force_sel == 2'd1) pwm_q <= 1'b0;
    else if (force_sel == 2'd2) pwm_q <= 1'b1;
    else begin
      unique case (sel)
        ACT_LOW:    pwm_q <= 1'b0;
        ACT_HIGH:   pwm_q <= 1'b1;
        ACT_TOGGLE: pwm_q <= ~pwm_q;
        default:    pwm_q <= pwm_q;
      endcase
    end
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/pwm_dual_aq.sv
module pwm_dual_aq
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 3,
  parameter int HS_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_wdata,
  output logic              pwm_a,
  output logic              pwm_b
);
  localparam int NCH     = 2;
  localparam int ACT_W   = $bits(action_cfg_t);
  localparam int TM_IMM  = 2;
  localparam int TM_CD   = 3;
  localparam int TM_HS   = TM_CD + DIV_W;
  localparam int TCTL_W  = TM_HS + HS_W;
  localparam int CC_STEP = 3;
  localparam int CCTL_W  = CC_STEP * NCH;
  localparam int FRC_W   = 2 * NCH;

  logic [TCTL_W-1:0]             tctl_q;
  logic [CCTL_W-1:0]             cmpctl_q;
  action_cfg_t [NCH-1:0]         aq_cfg_q;
  logic [FRC_W-1:0]              force_q;

  cnt_mode_e                     mode;
  logic                          tick, run, dir_up, ev_zero, ev_prd;
  logic [CNT_W-1:0]              cnt, per_eff;
  logic [NCH-1:0][CNT_W-1:0]     cmp_eff;
  logic [NCH-1:0]                cmp_up, cmp_dn, pwm_q;
  event_t                        ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      tctl_q   <= '0;
      cmpctl_q <= '0;
      aq_cfg_q <= '0;
      force_q  <= '0;
    end else if (cfg_we) begin
      unique case (cfg_addr)
        A_TIME:   tctl_q      <= cfg_wdata[TCTL_W-1:0];
        A_CMPCTL: cmpctl_q    <= cfg_wdata[CCTL_W-1:0];
        A_ACTA:   aq_cfg_q[0] <= action_cfg_t'(cfg_wdata[ACT_W-1:0]);
        A_ACTB:   aq_cfg_q[1] <= action_cfg_t'(cfg_wdata[ACT_W-1:0]);
        A_FORCE:  force_q     <= cfg_wdata[FRC_W-1:0];
        default:  ;
      endcase
    end
  end

  assign mode = cnt_mode_e'(tctl_q[1:0]);

  pwm_aq_prescale #(.DIV_W(DIV_W), .HS_W(HS_W)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .clkdiv (tctl_q[TM_CD +: DIV_W]),
    .hsdiv  (tctl_q[TM_HS +: HS_W]),
    .tick   (tick)
  );

  pwm_aq_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .mode      (mode),
    .per_imm   (tctl_q[TM_IMM]),
    .per_we    (cfg_we && (cfg_addr == A_PERIOD)),
    .per_wdata (cfg_wdata),
    .run       (run),
    .cnt       (cnt),
    .per_eff   (per_eff),
    .dir_up    (dir_up),
    .ev_zero   (ev_zero),
    .ev_prd    (ev_prd)
  );

  always_comb begin
    ev.at_zero = ev_zero;
    ev.at_prd  = ev_prd;
    ev.cmpa_up = cmp_up[0];
    ev.cmpa_dn = cmp_dn[0];
    ev.cmpb_up = cmp_up[1];
    ev.cmpb_dn = cmp_dn[1];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_aq_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk       (clk),
      .rst       (rst),
      .we        (cfg_we && (cfg_addr == (A_CMPA + ADDR_W'(g)))),
      .wdata     (cfg_wdata),
      .shadow_en (cmpctl_q[CC_STEP*g]),
      .load_sel  (load_sel_e'(cmpctl_q[CC_STEP*g+1 +: 2])),
      .run       (run),
      .ev_zero   (ev_zero),
      .ev_prd    (ev_prd),
      .cnt       (cnt),
      .dir_up    (dir_up),
      .cmp_eff   (cmp_eff[g]),
      .ev_up     (cmp_up[g]),
      .ev_dn     (cmp_dn[g])
    );

    pwm_aq_output u_out (
      .clk       (clk),
      .rst       (rst),
      .cfg       (aq_cfg_q[g]),
      .ev        (ev),
      .force_sel (force_q[2*g +: 2]),
      .pwm       (pwm_q[g])
    );
  end

  assign pwm_a = pwm_q[0];
  assign pwm_b = pwm_q[1];
endmodule

// File: rtl/pwm_dual_aq_chk.sv
module pwm_dual_aq_chk
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input cnt_mode_e        mode,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_eff,
  input logic             dir_up,
  input logic [CNT_W-1:0] cmp_a,
  input action_cfg_t      cfg_a,
  input logic [1:0]       force_sel_a,
  input logic             pwm_a
);
  logic released;
  assign released = (force_sel_a == 2'd0) || (force_sel_a == 2'd3);

  p_force_low_r12: assert property (@(posedge clk) disable iff (rst)
    (force_sel_a == 2'd1) |=> !pwm_a);

  p_force_high_r12: assert property (@(posedge clk) disable iff (rst)
    (force_sel_a == 2'd2) |=> pwm_a);

  p_quiet_between_ticks_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && released) |=> $stable(pwm_a));

  p_frozen_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_FREEZE) |=> $stable(cnt));

  p_frozen_out_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == CM_FREEZE && released) |=> $stable(pwm_a));

  p_up_step_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == CM_UP && cnt < per_eff) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_cmp_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (tick && mode != CM_FREEZE && released && dir_up && cnt == cmp_a &&
     cfg_a.cmpa_up == ACT_LOW && cfg_a.cmpb_up == ACT_NONE && cfg_a.cmpb_dn == ACT_NONE)
    |=> !pwm_a);
endmodule

bind pwm_dual_aq pwm_dual_aq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .mode        (mode),
  .cnt         (cnt),
  .per_eff     (per_eff),
  .dir_up      (dir_up),
  .cmp_a       (cmp_eff[0]),
  .cfg_a       (aq_cfg_q[0]),
  .force_sel_a (force_q[1:0]),
  .pwm_a       (pwm_a)
);

// File: tb/tb_pwm_dual_aq.sv
`timescale 1ns/1ps
module tb_pwm_dual_aq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        pwm_a, pwm_b;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  localparam int WD = 190000;
  localparam int LIM = 20000;

  always #5 clk = ~clk;

  pwm_dual_aq dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD) begin
      total++; bad++;
      $display("FAIL R3 watchdog expired actual=%0d expected<%0d", cyc, WD);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // {coarse exponent, fine divider, period, compare}
  localparam int NV = 5;
  localparam logic [37:0] VECS [NV] = '{
    {3'd0, 3'd0, 16'd9,  16'd3},
    {3'd1, 3'd0, 16'd19, 16'd5},
    {3'd0, 3'd1, 16'd7,  16'd7},
    {3'd2, 3'd3, 16'd4,  16'd1},
    {3'd3, 3'd2, 16'd49, 16'd20}
  };

  function automatic int divof(input int cd, input int hs);
    return (1 << cd) * ((hs == 0) ? 1 : 2 * hs);
  endfunction

  function automatic logic sig(input int ch);
    return (ch == 0) ? pwm_a : pwm_b;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setup(input int mode, input int imm, input int cd, input int hs,
                       input int p, input int ca, input int cb, input int aqa, input int aqb);
    do_reset();
    wr(1, p); wr(3, ca); wr(4, cb); wr(5, aqa); wr(6, aqb);
    wr(0, mode | (imm << 2) | (cd << 3) | (hs << 6));
  endtask

  // Skips one full pulse, then reports high time and full period in clocks.
  task automatic measure(input int ch, output int hi, output int per);
    int n;
    n = 0; hi = -1; per = -1;
    while (sig(ch) == 1'b1 && n < LIM) begin @(negedge clk); n++; end
    while (sig(ch) == 1'b0 && n < LIM) begin @(negedge clk); n++; end
    while (sig(ch) == 1'b1 && n < LIM) begin @(negedge clk); n++; end
    while (sig(ch) == 1'b0 && n < LIM) begin @(negedge clk); n++; end
    if (n >= LIM) return;
    hi = 0;
    while (sig(ch) == 1'b1 && n < LIM) begin @(negedge clk); hi++; n++; end
    per = hi;
    while (sig(ch) == 1'b0 && n < LIM) begin @(negedge clk); per++; n++; end
    if (n >= LIM) begin hi = -1; per = -1; end
  endtask

  task automatic hold(input int ch, input logic v, input int cnt, output int miss);
    miss = 0;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      if (sig(ch) !== v) miss++;
    end
  endtask

  initial begin
    int hi, per, miss;
    logic v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2: reset state, both outputs low
    hold(0, 1'b0, 40, miss); chk("R2 pwm_a low after reset", miss, 0);
    hold(1, 1'b0, 40, miss); chk("R2 pwm_b low after reset", miss, 0);

    // R1 R3 R4 R8 R10: up-mode vectors, A normal polarity, B inverted
    for (int i = 0; i < NV; i++) begin
      int cd, hs, p, c, d;
      cd = int'(VECS[i][37:35]);
      hs = int'(VECS[i][34:32]);
      p  = int'(VECS[i][31:16]);
      c  = int'(VECS[i][15:0]);
      d  = divof(cd, hs);
      setup(0, i % 2, cd, hs, p, c, c, 'h012, 'h201);
      measure(0, hi, per);
      chk("R1 R4 A high time", hi, c * d);
      chk("R3 R4 A period", per, (p + 1) * d);
      measure(1, hi, per);
      chk("R10 R12 B inverted high time", hi, (p + 1 - c) * d);
      chk("R3 R8 B period", per, (p + 1) * d);
    end

    // R10: toggle on zero gives a square wave of two periods
    setup(0, 1, 0, 0, 4, 0, 0, 'h003, 'h000);
    measure(0, hi, per);
    chk("R10 toggle high", hi, 5);
    chk("R10 toggle period", per, 10);

    // R11: compare of 0 beats the zero action
    setup(0, 1, 0, 0, 9, 0, 0, 'h012, 'h000);
    repeat (20) @(negedge clk);
    hold(0, 1'b0, 60, miss); chk("R11 compare 0 constant low", miss, 0);

    // R5: down mode
    setup(1, 1, 0, 0, 9, 3, 0, 'h042, 'h000);
    measure(0, hi, per);
    chk("R5 down high", hi, 7);
    chk("R5 down period", per, 10);

    // R6: up-down mode
    setup(2, 1, 0, 0, 8, 3, 0, 'h061, 'h000);
    measure(0, hi, per);
    chk("R6 updown high", hi, 10);
    chk("R6 updown period", per, 16);

    // R7: freeze stops the toggling output
    setup(0, 1, 0, 0, 9, 0, 0, 'h003, 'h000);
    repeat (23) @(negedge clk);
    wr(0, 3 | (1 << 2));
    @(negedge clk);
    v = pwm_a;
    hold(0, v, 100, miss); chk("R7 frozen output", miss, 0);

    // R9: compare shadow with different load points
    setup(0, 1, 0, 0, 9, 3, 0, 'h012, 'h000);
    wr(2, 'h7);
    measure(0, hi, per); chk("R9 shadow initial high", hi, 3);
    wr(3, 6);
    repeat (30) @(negedge clk);
    measure(0, hi, per); chk("R9 never-load keeps old compare", hi, 3);
    wr(2, 'h1);
    repeat (30) @(negedge clk);
    measure(0, hi, per); chk("R9 load at zero", hi, 6);
    wr(2, 'h3); wr(3, 2);
    repeat (30) @(negedge clk);
    measure(0, hi, per); chk("R9 load at period", hi, 2);

    // R8: shadowed period write takes effect
    setup(0, 0, 0, 0, 9, 3, 0, 'h012, 'h000);
    measure(0, hi, per); chk("R8 shadow period before", per, 10);
    wr(1, 19);
    repeat (40) @(negedge clk);
    measure(0, hi, per); chk("R8 shadow period after", per, 20);

    // R12: software force per channel
    setup(0, 1, 0, 0, 9, 3, 5, 'h012, 'h201);
    wr(7, 'h2);
    hold(0, 1'b1, 60, miss); chk("R12 A forced high", miss, 0);
    measure(1, hi, per); chk("R12 B unaffected by A force", hi, 5);
    wr(7, 'h4);
    hold(1, 1'b0, 60, miss); chk("R12 B forced low", miss, 0);
    measure(0, hi, per); chk("R12 A released", hi, 3);
    wr(7, 'h8);
    hold(1, 1'b1, 60, miss); chk("R12 B forced high", miss, 0);
    wr(7, 'h1);
    hold(0, 1'b0, 60, miss); chk("R12 A forced low", miss, 0);
    wr(7, 'h3);
    measure(0, hi, per); chk("R12 code 3 releases A", hi, 3);

    // R2: reset mid-run clears configuration
    do_reset();
    hold(0, 1'b0, 50, miss); chk("R2 reset mid-run A low", miss, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule